// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank-State Checker

This block watches the control pins of a DDR SDRAM interface. On every rising clock edge it samples clock enable, chip select, the three strobes RAS, CAS and WE, two bank-select bits and the address bus. The current clock enable is compared with a registered copy of its previous level, so power-down and self-refresh transitions are told apart from ordinary commands. Each sample becomes exactly one command code. The code is presented one cycle later, together with the bank, the row, column or operand field and the auto-precharge flag.

Alongside the decode, the block keeps an open/precharged bit for each of the four banks and the burst length taken from the last accepted base mode-register write. A countdown follows the burst and precharge-recovery window after a write with auto precharge. A command that breaks an ordering rule raises a one-cycle error pulse with a reason code, and it leaves the bank tracking untouched. The block suits a protocol monitor placed beside a memory controller, in simulation or in silicon.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high in both the previous and current sample and chip select low, the strobe pattern RAS,CAS,WE decodes as follows: LLL gives mode write (code 2 when bank bit 0 is low, code 3 when it is high), LLH gives refresh (4), LHH gives activate (6), HLH gives read (7), HLL gives write (8), HHL gives burst stop (11) and HHH gives NOP (0).
- R2: With both clock-enable samples high and chip select high, the sample decodes as deselect (code 1) whatever the other pins carry, and the bank state is unchanged.
- R3: Clock enable low then high decodes as low-power exit (14), and low then low decodes as NOP (0). High then low decodes as self-refresh entry (5) when chip select is low with the refresh strobe pattern. Otherwise it decodes as power-down entry: code 12 when every bank is precharged and code 13 when any bank is open.
- R4: The bank output equals the two bank-select bits (value 0 to 3 names banks A to D) for activate, read, write and single-bank precharge. The address output carries the full row for activate, address bits 9..0 zero-extended for read and write, and the full operand for mode writes. The auto-precharge output equals address bit 10 for read and write.
- R5: Precharge (strobes LHL) with address bit 10 high decodes as precharge-all (10) with bank output 0 and closes every bank. With bit 10 low it decodes as precharge (9) and closes only the selected bank. An accepted read or write with bit 10 high closes its bank.
- R6: A mode write, refresh or self-refresh entry sampled while any bank is open gives error code 1.
- R7: A read or write to a precharged bank gives error code 2. An activate to an open bank gives error code 3.
- R8: After an accepted write with bit 10 high, any read or write in the following BL/2 samples gives error code 4.
- R9: An activate to the bank of that write within the following BL/2 + TRP samples gives error code 5. The first activate after that window is accepted.
- R10: An accepted base mode write (code 2) sets the burst length from address bits 2..0: 1 gives 2, 2 gives 4 and 3 gives 8. Other values keep the current length. After reset the length is DEF_BL (4).
- R11: A command that raises an error changes neither the bank states nor the burst length.
- R12: Reset marks all banks precharged, drives every output to zero and treats the previous clock enable as low.
- R13: All outputs are registered. They show the sample taken at a rising edge from that edge on, and the error pulse is high only for samples that break a rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, current level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select bits |
| addr | input | ADDR_W | Address bus |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | 2 | Bank index of the command |
| cmd_addr | output | ADDR_W | Row, column or operand field |
| cmd_ap | output | 1 | Auto-precharge requested |
| err_pulse | output | 1 | Rule violation for this sample |
| err_code | output | 3 | Reason code, 0 when no error |

## Verification
The bench aims at the edges of the auto-precharge window. It checks the last flagged sample and the first accepted one for both the burst and the recovery part. A counter that is off by one, or that reloads from a stale burst length, misplaces exactly those samples. It also checks that rejected activates and mode writes leave no trace: a design that updates state on an error would later accept a read it should refuse, or would shorten the burst. Clock-enable decoding is driven through every transition pair, so swapping active and precharge power-down or mistaking the first sample after reset for an ordinary command is caught.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_DESEL   = 4'd1,
    CMD_MRS     = 4'd2,
    CMD_EMRS    = 4'd3,
    CMD_REF     = 4'd4,
    CMD_SREF_IN = 4'd5,
    CMD_ACT     = 4'd6,
    CMD_RD      = 4'd7,
    CMD_WR      = 4'd8,
    CMD_PRE     = 4'd9,
    CMD_PREA    = 4'd10,
    CMD_BST     = 4'd11,
    CMD_PDP_IN  = 4'd12,
    CMD_PDA_IN  = 4'd13,
    CMD_LP_EXIT = 4'd14
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_NOT_IDLE   = 3'd1,
    ERR_ROW_CLOSED = 3'd2,
    ERR_ROW_OPEN   = 3'd3,
    ERR_BURST_BUSY = 3'd4,
    ERR_RECOVERY   = 3'd5
  } err_e;

  // New burst length from a mode operand; unknown codes keep the current one.
  function automatic logic [3:0] bl_from_opcode(input logic [2:0] op,
                                                input logic [3:0] cur);
    case (op)
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd8;
      default: return cur;
    endcase
  endfunction

  // Clocks a DDR burst occupies: two beats per clock.
  function automatic logic [3:0] burst_clocks(input logic [3:0] bl);
    return bl >> 1;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic mode_sel,
  input  logic ap_bit,
  input  logic all_idle,
  output cmd_e cmd
);

  logic [2:0] strobes;
  assign strobes = {ras_n, cas_n, we_n};

  always_comb begin
    cmd = CMD_NOP;
    case ({cke_prev, cke})
      2'b01: cmd = CMD_LP_EXIT;
      2'b00: cmd = CMD_NOP;
      2'b10: begin
        if (!cs_n && strobes == 3'b001) cmd = CMD_SREF_IN;
        else                             cmd = all_idle ? CMD_PDP_IN : CMD_PDA_IN;
      end
      default: begin
        if (cs_n) cmd = CMD_DESEL;
        else begin
          case (strobes)
            3'b000:  cmd = mode_sel ? CMD_EMRS : CMD_MRS;
            3'b001:  cmd = CMD_REF;
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = ap_bit ? CMD_PREA : CMD_PRE;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NOP;
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_mon_pkg::*;
#(
  parameter int DEF_BL = 4,
  parameter int TRP    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_e       cmd,
  input  logic [1:0] ba,
  input  logic       ap_bit,
  input  logic [2:0] opcode,
  output logic       all_idle,
  output err_e       err
);

  localparam int NBANK = 4;
  localparam int CNT_W = $clog2(4 + TRP + 1);

  logic [NBANK-1:0] open_q;
  logic [3:0]       bl_q;
  logic [CNT_W-1:0] rec_cnt;
  logic [1:0]       ap_bank_q;

  // Named internal events.
  logic burst_busy, rec_active, accept;
  logic acc_act, acc_pre, acc_prea, acc_rd_ap, wr_ap_start, acc_bl;
  logic idle_cmd;
  logic [CNT_W-1:0] rec_load;

  assign all_idle   = (open_q == '0);
  assign burst_busy = (rec_cnt > CNT_W'(TRP));
  assign rec_active = (rec_cnt != '0);
  assign rec_load   = CNT_W'(burst_clocks(bl_q)) + CNT_W'(TRP);
  assign idle_cmd   = (cmd == CMD_MRS) || (cmd == CMD_EMRS) ||
                      (cmd == CMD_REF) || (cmd == CMD_SREF_IN);

  always_comb begin
    err = ERR_NONE;
    if (idle_cmd) begin
      if (!all_idle) err = ERR_NOT_IDLE;
    end else if (cmd == CMD_RD || cmd == CMD_WR) begin
      if (burst_busy)        err = ERR_BURST_BUSY;
      else if (!open_q[ba])  err = ERR_ROW_CLOSED;
    end else if (cmd == CMD_ACT) begin
      if (rec_active && ap_bank_q == ba) err = ERR_RECOVERY;
      else if (open_q[ba])               err = ERR_ROW_OPEN;
    end
  end

  assign accept      = (err == ERR_NONE);
  assign acc_act     = accept && cmd == CMD_ACT;
  assign acc_pre     = accept && cmd == CMD_PRE;
  assign acc_prea    = accept && cmd == CMD_PREA;
  assign acc_rd_ap   = accept && cmd == CMD_RD && ap_bit;
  assign wr_ap_start = accept && cmd == CMD_WR && ap_bit;
  assign acc_bl      = accept && cmd == CMD_MRS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= '0;
      bl_q      <= 4'(DEF_BL);
      rec_cnt   <= '0;
      ap_bank_q <= '0;
    end else begin
      if (acc_act)                            open_q[ba] <= 1'b1;
      if (acc_pre || acc_rd_ap || wr_ap_start) open_q[ba] <= 1'b0;
      if (acc_prea)                           open_q     <= '0;
      if (acc_bl)                             bl_q <= bl_from_opcode(opcode, bl_q);
      if (wr_ap_start) begin
        rec_cnt   <= rec_load;
        ap_bank_q <= ba;
      end else if (rec_active) begin
        rec_cnt <= rec_cnt - CNT_W'(1);
      end
    end
  end

  // Accepted activate leaves the bank open (R7).
  p_act_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_act |=> open_q[$past(ba)]);

  // Precharge-all empties the bank map (R5).
  p_prea_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_prea |=> (open_q == '0));

  // Mode and refresh commands accepted only with all banks idle (R6).
  p_idle_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cmd && accept) |-> (open_q == '0));

  // No column command during a write burst with auto precharge (R8).
  p_burst_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_busy && (cmd == CMD_RD || cmd == CMD_WR)) |-> (err == ERR_BURST_BUSY));

  // Recovery window counts down one per sample (R9).
  p_rec_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_active && !wr_ap_start) |=> (rec_cnt == $past(rec_cnt) - CNT_W'(1)));

  // Rejected commands leave bank state and burst length alone (R11).
  p_reject_keeps_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(open_q) && $stable(bl_q)));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int DEF_BL = 4,
  parameter int TRP    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        cmd_code,
  output logic [1:0]        cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ap,
  output logic              err_pulse,
  output logic [2:0]        err_code
);

  logic cke_q;
  logic all_idle;
  cmd_e cmd;
  err_e err;
  logic bank_cmd, col_cmd, mode_cmd;
  logic [ADDR_W-1:0] addr_field;

  sdram_cmd_decode u_decode (
    .cke_prev (cke_q),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .mode_sel (ba[0]),
    .ap_bit   (addr[AP_BIT]),
    .all_idle (all_idle),
    .cmd      (cmd)
  );

  sdram_bank_tracker #(.DEF_BL(DEF_BL), .TRP(TRP)) u_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .ba       (ba),
    .ap_bit   (addr[AP_BIT]),
    .opcode   (addr[2:0]),
    .all_idle (all_idle),
    .err      (err)
  );

  assign col_cmd  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign bank_cmd = col_cmd || (cmd == CMD_ACT) || (cmd == CMD_PRE);
  assign mode_cmd = (cmd == CMD_MRS) || (cmd == CMD_EMRS);

  always_comb begin
    addr_field = '0;
    if (cmd == CMD_ACT || mode_cmd) addr_field = addr;
    else if (col_cmd)               addr_field = ADDR_W'(addr[COL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b0;
      cmd_code  <= '0;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cmd_ap    <= 1'b0;
      err_pulse <= 1'b0;
      err_code  <= '0;
    end else begin
      cke_q     <= cke;
      cmd_code  <= cmd;
      cmd_bank  <= bank_cmd ? ba : 2'd0;
      cmd_addr  <= addr_field;
      cmd_ap    <= col_cmd && addr[AP_BIT];
      err_pulse <= (err != ERR_NONE);
      err_code  <= err;
    end
  end

  // First high sample after a low one is reported as an exit (R3).
  p_exit_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_q && cke) |=> (cmd_code == CMD_LP_EXIT));

  // Pulse and reason agree on every registered sample (R13).
  p_err_reason_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse == (err_code != 3'd0));

  // Deselect never produces an error (R2).
  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DESEL) |=> !err_pulse);

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [2:0] S_MRS = 3'b000, S_REF = 3'b001, S_ACT = 3'b011,
                         S_RD  = 3'b101, S_WR  = 3'b100, S_PRE = 3'b010,
                         S_BST = 3'b110, S_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        cmd_ap, err_pulse;
  logic [2:0]  err_code;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_ap(cmd_ap), .err_pulse(err_pulse), .err_code(err_code)
  );

  // {req, cke, cs_n, strobes, ba, addr, expected cmd, expected err}
  localparam int NV = 26;
  localparam logic [30:0] VEC [NV] = '{
    {4'd3,  1'b1,1'b1,S_NOP,2'd0,13'h0000,4'd14,3'd0}, // R3 first sample after reset
    {4'd2,  1'b1,1'b1,S_MRS,2'd0,13'h0000,4'd1, 3'd0}, // R2 deselect masks pins
    {4'd2,  1'b1,1'b0,S_NOP,2'd0,13'h0000,4'd0, 3'd0}, // R2 nop
    {4'd10, 1'b1,1'b0,S_MRS,2'd0,13'h0002,4'd2, 3'd0}, // R10 base mode, BL4
    {4'd1,  1'b1,1'b0,S_MRS,2'd1,13'h0010,4'd3, 3'd0}, // R1 extended mode
    {4'd1,  1'b1,1'b0,S_REF,2'd0,13'h0000,4'd4, 3'd0}, // R1 refresh
    {4'd1,  1'b1,1'b0,S_ACT,2'd2,13'h1234,4'd6, 3'd0}, // R1 activate C
    {4'd1,  1'b1,1'b0,S_RD, 2'd2,13'h0055,4'd7, 3'd0}, // R1 read
    {4'd1,  1'b1,1'b0,S_WR, 2'd2,13'h0055,4'd8, 3'd0}, // R1 write
    {4'd7,  1'b1,1'b0,S_RD, 2'd3,13'h0000,4'd7, 3'd2}, // R7 read closed bank
    {4'd7,  1'b1,1'b0,S_ACT,2'd2,13'h0000,4'd6, 3'd3}, // R7 activate open bank
    {4'd6,  1'b1,1'b0,S_REF,2'd0,13'h0000,4'd4, 3'd1}, // R6 refresh while open
    {4'd6,  1'b1,1'b0,S_MRS,2'd0,13'h0003,4'd2, 3'd1}, // R6 R11 rejected mode, BL stays
    {4'd13, 1'b1,1'b0,S_BST,2'd0,13'h0000,4'd11,3'd0}, // R13 pulse drops
    {4'd3,  1'b0,1'b1,S_NOP,2'd0,13'h0000,4'd13,3'd0}, // R3 active power-down
    {4'd3,  1'b0,1'b1,S_NOP,2'd0,13'h0000,4'd0, 3'd0}, // R3 stays low
    {4'd3,  1'b1,1'b1,S_NOP,2'd0,13'h0000,4'd14,3'd0}, // R3 exit
    {4'd5,  1'b1,1'b0,S_PRE,2'd2,13'h0000,4'd9, 3'd0}, // R5 single precharge
    {4'd5,  1'b1,1'b0,S_RD, 2'd2,13'h0000,4'd7, 3'd2}, // R5 bank now closed
    {4'd1,  1'b1,1'b0,S_ACT,2'd0,13'h0100,4'd6, 3'd0}, // R1 activate A
    {4'd5,  1'b1,1'b0,S_PRE,2'd3,13'h0400,4'd10,3'd0}, // R5 precharge all
    {4'd3,  1'b0,1'b1,S_NOP,2'd0,13'h0000,4'd12,3'd0}, // R3 precharge power-down
    {4'd3,  1'b1,1'b1,S_NOP,2'd0,13'h0000,4'd14,3'd0}, // R3 exit
    {4'd3,  1'b0,1'b0,S_REF,2'd0,13'h0000,4'd5, 3'd0}, // R3 self-refresh entry
    {4'd3,  1'b0,1'b0,S_REF,2'd0,13'h0000,4'd0, 3'd0}, // R3 held low
    {4'd3,  1'b1,1'b1,S_NOP,2'd0,13'h0000,4'd14,3'd0}  // R3 exit
  };

  task automatic step(input logic c, input logic s, input logic [2:0] st,
                      input logic [1:0] b, input logic [12:0] a);
    cke = c; cs_n = s; {ras_n, cas_n, we_n} = st; ba = b; addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd1(input logic [2:0] st, input logic [1:0] b, input logic [12:0] a);
    step(1'b1, 1'b0, st, b, a);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset cmd", cmd_code, 0);
    chk("R12 reset err", err_pulse, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      step(v[26], v[25], v[24:22], v[21:20], v[19:7]);
      chk($sformatf("R%0d row %0d cmd", v[30:27], i), cmd_code, v[6:3]);
      chk($sformatf("R%0d row %0d err", v[30:27], i), err_code, v[2:0]);
      chk($sformatf("R%0d row %0d pulse", v[30:27], i), err_pulse, v[2:0] != 0);
    end

    // R4 fields
    cmd1(S_ACT, 2'd1, 13'h1ABC);
    chk("R4 act bank", cmd_bank, 1);
    chk("R4 act row", cmd_addr, 13'h1ABC);
    cmd1(S_RD, 2'd1, 13'h07FF);
    chk("R4 rd cmd", cmd_code, 7);
    chk("R4 rd col", cmd_addr, 13'h03FF);
    chk("R4 rd ap", cmd_ap, 1);
    chk("R4 rd bank", cmd_bank, 1);
    cmd1(S_RD, 2'd1, 13'h0000);
    chk("R5 read-ap closed bank", err_code, 2);

    // R8 R9 R11 with BL4, TRP3: burst k+1..k+2, recovery to k+5
    cmd1(S_ACT, 2'd0, 13'h0001);
    cmd1(S_ACT, 2'd2, 13'h0002);
    cmd1(S_WR, 2'd0, 13'h0400);
    chk("R8 write-ap accepted", err_code, 0);
    cmd1(S_RD, 2'd2, 13'h0000);
    chk("R8 burst k+1", err_code, 4);
    cmd1(S_RD, 2'd2, 13'h0000);
    chk("R8 burst k+2", err_code, 4);
    cmd1(S_RD, 2'd2, 13'h0000);
    chk("R8 burst over k+3", err_code, 0);
    cmd1(S_ACT, 2'd0, 13'h0000);
    chk("R9 recovery k+4", err_code, 5);
    cmd1(S_ACT, 2'd0, 13'h0000);
    chk("R9 recovery k+5", err_code, 5);
    cmd1(S_ACT, 2'd0, 13'h0000);
    chk("R9 R11 first accepted k+6", err_code, 0);
    cmd1(S_ACT, 2'd0, 13'h0000);
    chk("R7 now open", err_code, 3);

    // R10 burst length 2, then an invalid operand keeps it
    for (int pass = 0; pass < 2; pass++) begin
      cmd1(S_PRE, 2'd0, 13'h0400);
      cmd1(S_MRS, 2'd0, pass == 0 ? 13'h0001 : 13'h0007);
      chk("R10 mode accepted", err_code, 0);
      cmd1(S_ACT, 2'd3, 13'h0000);
      cmd1(S_ACT, 2'd0, 13'h0000);
      cmd1(S_WR, 2'd0, 13'h0400);
      cmd1(S_RD, 2'd3, 13'h0000);
      chk("R10 BL2 burst k+1", err_code, 4);
      cmd1(S_RD, 2'd3, 13'h0000);
      chk("R10 BL2 over k+2", err_code, 0);
    end

    // R12 reset mid-run with bank 3 open
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 async reset cmd", cmd_code, 0);
    chk("R12 async reset err", err_code, 0);
    rst_n = 1'b1;
    step(1'b1, 1'b0, S_NOP, 2'd0, 13'h0000);
    chk("R12 prev cke low", cmd_code, 14);
    cmd1(S_RD, 2'd3, 13'h0000);
    chk("R12 banks precharged", err_code, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule